// File: doc/BRIEF.md
# SD Host Command Issue Controller

This block accepts one SD command request at a time (a 6-bit command index, a 32-bit argument, a response-kind code, a command-kind code and per-command enables for index and CRC checking). It holds the request until the line engine reports that neither the command path nor the data path is inhibited. It then emits a one-cycle launch pulse to that engine, carrying the command fields.

After launch it watches the status flags that the line engine raises: command complete, response timeout, index error, end-bit error, CRC error and card removal. Flags are accumulated from the launch onward. As soon as a completion or an error is seen, or a poll window expires, it reports one prioritised result code with a done pulse. On success it captures the response words. Bit serialisation, CRC generation and data-line traffic belong to the line engine and lie outside this block.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, `done`, `launch` and all bits of `rsp_out` are 0.
- R2: While either `cmd_inhibit` or `dat_inhibit` is 1 a pending request does not launch. One clock edge after both are 0, `launch` pulses for one cycle. During that pulse, `launch_index`, `launch_arg`, `launch_kind`, `launch_idx_chk` and `launch_crc_chk` equal the requested values.
- R3: Response kinds are encoded 0 = none, 1 = 136-bit, 2 = 48-bit, 3 = 48-bit then busy. A request with command kind 3 (abort) always launches with response kind 3, whatever kind was requested. Other command kinds keep the requested response kind.
- R4: `done` is a one-cycle pulse that appears one edge after the finishing flag. `result` is 0 for success, 1 for error, 3 for not ready and 5 for no response.
- R5: Any error flag that is in effect (index error, end-bit error, CRC error) yields result 1. This outranks removal and timeout.
- R6: Index error is ignored when the request's index check enable is 0. CRC error is ignored when its CRC check enable is 0. A clean completion then yields result 0.
- R7: A card-removal event between launch and completion yields result 3, even when the timeout flag is also set.
- R8: A timeout flag together with a completion and no error or removal yields result 5.
- R9: A removal event seen before launch, while the request is pending, is not reported.
- R10: If neither completion nor an error is seen, the command ends with result 1. `done` then appears exactly `POLL_LIMIT` cycles after the launch pulse.
- R11: `rsp_out` loads `rsp_in` only when a command ends with result 0. Otherwise it keeps its value.
- R12: A request presented while a command is pending or in flight is ignored. No second launch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp_kind | input | 2 | Response kind code |
| req_cmd_kind | input | 2 | Command kind, 3 = abort |
| req_idx_chk | input | 1 | Enable index error checking |
| req_crc_chk | input | 1 | Enable CRC error checking |
| cmd_inhibit | input | 1 | Command path busy |
| dat_inhibit | input | 1 | Data path busy |
| launch | output | 1 | One-cycle start pulse to line engine |
| launch_index | output | 6 | Launched command index |
| launch_arg | output | 32 | Launched argument |
| launch_rsp_kind | output | 2 | Launched response kind |
| launch_kind | output | 2 | Launched command kind |
| launch_idx_chk | output | 1 | Launched index check enable |
| launch_crc_chk | output | 1 | Launched CRC check enable |
| ev_complete | input | 1 | Command complete flag |
| ev_timeout | input | 1 | Response timeout flag |
| ev_index_err | input | 1 | Index error flag |
| ev_endbit_err | input | 1 | End-bit error flag |
| ev_crc_err | input | 1 | CRC error flag |
| ev_removal | input | 1 | Card removal event |
| rsp_in | input | 128 | Response words from line engine |
| done | output | 1 | Result valid pulse |
| result | output | 3 | Result code |
| rsp_out | output | 128 | Captured response words |

## Verification
Removal, timeout and error flags can arrive in the same cycle as the completion flag. The priority between them then decides the result. The bench provokes this both by directed cases and by random draws that raise any mix of flags in the finishing cycle. It also places removal pulses in an earlier cycle or together with the completion. Each outcome is judged against a bench function that applies the order error, then removal, then timeout, then success. The bench also checks that response capture follows only the success outcome.

// File: rtl/sd_cmd_issue_pkg.sv
// Shared codes and types for the SD command issue controller.
// Assumes: response-kind, command-kind and result encodings are fixed by the line engine.
package sd_cmd_issue_pkg;
    localparam logic [1:0] RSP_NONE    = 2'd0;
    localparam logic [1:0] RSP_LONG    = 2'd1;
    localparam logic [1:0] RSP_SHORT   = 2'd2;
    localparam logic [1:0] RSP_SHORT_B = 2'd3;
    localparam logic [1:0] KIND_ABORT  = 2'd3;

    typedef enum logic [2:0] {
        RES_OK          = 3'd0,
        RES_ERROR       = 3'd1,
        RES_NOT_READY   = 3'd3,
        RES_NO_RESPONSE = 3'd5
    } result_e;

    typedef struct packed {
        logic cmpl;
        logic tmo;
        logic idx_err;
        logic end_err;
        logic crc_err;
        logic removed;
    } cmd_flags_t;

    typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_WAIT} issue_state_e;
endpackage

// File: rtl/sd_cmd_flag_acc.sv
// Accumulates line-engine status flags while a command is in flight.
// Masks index and CRC errors by their per-command enables.
// Assumes: flags are one-cycle pulses; accumulation restarts whenever active is low.
module sd_cmd_flag_acc
    import sd_cmd_issue_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       idx_en,
    input  logic       crc_en,
    input  logic       ev_complete,
    input  logic       ev_timeout,
    input  logic       ev_index_err,
    input  logic       ev_endbit_err,
    input  logic       ev_crc_err,
    input  logic       ev_removal,
    output cmd_flags_t flags_now
);
    cmd_flags_t sticky_q;
    cmd_flags_t incoming;

    // Masked view of this cycle's flags.
    always_comb begin
        incoming.cmpl    = ev_complete;
        incoming.tmo     = ev_timeout;
        incoming.idx_err = ev_index_err & idx_en;
        incoming.end_err = ev_endbit_err;
        incoming.crc_err = ev_crc_err & crc_en;
        incoming.removed = ev_removal;
        flags_now = active ? (sticky_q | incoming) : '0;
    end

    // Sticky store, emptied whenever no command is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) sticky_q <= '0;
        else                   sticky_q <= flags_now;
    end

    // R6: a masked index error never reaches the accumulated view.
    a_r6_idx_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !idx_en && !sticky_q.idx_err) |-> !flags_now.idx_err);
endmodule

// File: rtl/sd_cmd_poll_timer.sv
// Counts polling cycles of one command and flags expiry on the last one.
// Assumes: LIMIT >= 2; run stays high for the whole wait.
module sd_cmd_poll_timer #(
    parameter int LIMIT = 1 << 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count_q;

    assign expired = run && (count_q == LAST);

    // Advance while running, restart on idle or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired) count_q <= '0;
        else                           count_q <= count_q + 1'b1;
    end

    // R10: the counter never passes the last polling cycle.
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST);
endmodule

// File: rtl/sd_cmd_result_sel.sv
// Reduces accumulated flags and the poll expiry to a finish strobe and result code.
// Priority: error flags, then missing completion, then removal, then timeout.
module sd_cmd_result_sel
    import sd_cmd_issue_pkg::*;
(
    input  cmd_flags_t flags,
    input  logic       expired,
    output logic       finish,
    output result_e    code
);
    logic any_err;

    // Pick the outcome of the first terminating observation.
    always_comb begin
        any_err = flags.idx_err | flags.end_err | flags.crc_err;
        finish  = flags.cmpl | any_err | expired;
        if (any_err || !flags.cmpl) code = RES_ERROR;
        else if (flags.removed)     code = RES_NOT_READY;
        else if (flags.tmo)         code = RES_NO_RESPONSE;
        else                        code = RES_OK;
    end
endmodule

// File: rtl/sd_cmd_issue.sv
// SD command issue controller: holds one request until the command and data paths
// are free, launches it, then resolves the engine's status flags into a result.
// Assumes: engine flags are one-cycle pulses and rsp_in is valid with completion.
module sd_cmd_issue
    import sd_cmd_issue_pkg::*;
#(
    parameter int POLL_LIMIT    = 1 << 24,
    parameter int NUM_RSP_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [5:0]                  req_index,
    input  logic [31:0]                 req_arg,
    input  logic [1:0]                  req_rsp_kind,
    input  logic [1:0]                  req_cmd_kind,
    input  logic                        req_idx_chk,
    input  logic                        req_crc_chk,
    input  logic                        cmd_inhibit,
    input  logic                        dat_inhibit,
    output logic                        launch,
    output logic [5:0]                  launch_index,
    output logic [31:0]                 launch_arg,
    output logic [1:0]                  launch_rsp_kind,
    output logic [1:0]                  launch_kind,
    output logic                        launch_idx_chk,
    output logic                        launch_crc_chk,
    input  logic                        ev_complete,
    input  logic                        ev_timeout,
    input  logic                        ev_index_err,
    input  logic                        ev_endbit_err,
    input  logic                        ev_crc_err,
    input  logic                        ev_removal,
    input  logic [NUM_RSP_WORDS*32-1:0] rsp_in,
    output logic                        done,
    output logic [2:0]                  result,
    output logic [NUM_RSP_WORDS*32-1:0] rsp_out
);
    localparam int RSP_W = NUM_RSP_WORDS * 32;

    issue_state_e state_q;
    cmd_flags_t   flags_now;
    logic         expired;
    logic         finish;
    result_e      code;
    logic         waiting;
    logic         paths_free;
    logic         capture;

    assign waiting    = (state_q == ST_WAIT);
    assign paths_free = !cmd_inhibit && !dat_inhibit;
    assign capture    = waiting && finish && (code == RES_OK);

    sd_cmd_flag_acc u_flags (
        .clk(clk), .rst_n(rst_n), .active(waiting),
        .idx_en(launch_idx_chk), .crc_en(launch_crc_chk),
        .ev_complete(ev_complete), .ev_timeout(ev_timeout),
        .ev_index_err(ev_index_err), .ev_endbit_err(ev_endbit_err),
        .ev_crc_err(ev_crc_err), .ev_removal(ev_removal),
        .flags_now(flags_now)
    );

    sd_cmd_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(waiting), .expired(expired)
    );

    sd_cmd_result_sel u_sel (
        .flags(flags_now), .expired(expired), .finish(finish), .code(code)
    );

    // Sequencer: idle -> pending -> waiting -> idle, with launch and done pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            launch  <= 1'b0;
            done    <= 1'b0;
            result  <= 3'd0;
        end else begin
            launch <= 1'b0;
            done   <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) state_q <= ST_PEND;
                ST_PEND: if (paths_free) begin
                    state_q <= ST_WAIT;
                    launch  <= 1'b1;
                end
                ST_WAIT: if (finish) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                    result  <= code;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture; abort commands are forced to the busy-signalling response kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch_index    <= '0;
            launch_arg      <= '0;
            launch_rsp_kind <= RSP_NONE;
            launch_kind     <= '0;
            launch_idx_chk  <= 1'b0;
            launch_crc_chk  <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            launch_index    <= req_index;
            launch_arg      <= req_arg;
            launch_rsp_kind <= (req_cmd_kind == KIND_ABORT) ? RSP_SHORT_B : req_rsp_kind;
            launch_kind     <= req_cmd_kind;
            launch_idx_chk  <= req_idx_chk;
            launch_crc_chk  <= req_crc_chk;
        end
    end

    // Response words, each loaded only on a successful finish.
    for (genvar w = 0; w < NUM_RSP_WORDS; w++) begin : g_rsp
        always_ff @(posedge clk) begin
            if (!rst_n)       rsp_out[w*32 +: 32] <= '0;
            else if (capture) rsp_out[w*32 +: 32] <= rsp_in[w*32 +: 32];
        end
    end

    // R2: launch only follows a cycle with both paths free.
    a_r2_launch_free: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(paths_free));
    // R3: abort commands leave with the busy-signalling response kind.
    a_r3_abort_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && launch_kind == KIND_ABORT) |-> (launch_rsp_kind == RSP_SHORT_B));
    // R4: done is a single-cycle pulse carrying a legal code.
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == 3'd0 || result == 3'd1 || result == 3'd3 || result == 3'd5));
    // R11: response words change only with a successful done.
    a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_out != $past(rsp_out)) |-> (done && result == 3'd0));
    // R12: a second launch never happens without an intervening done.
    a_r12_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && $past(launch)) |-> 1'b0);

    logic [RSP_W-1:0] unused_chk;
    assign unused_chk = '0;
endmodule

// File: tb/tb_sd_cmd_issue.sv
module tb_sd_cmd_issue;
    localparam int LIMIT = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [5:0] req_index = '0;
    logic [31:0] req_arg = '0;
    logic [1:0] req_rsp_kind = '0, req_cmd_kind = '0;
    logic req_idx_chk = 1'b0, req_crc_chk = 1'b0;
    logic cmd_inhibit = 1'b0, dat_inhibit = 1'b0;
    logic launch;
    logic [5:0] launch_index;
    logic [31:0] launch_arg;
    logic [1:0] launch_rsp_kind, launch_kind;
    logic launch_idx_chk, launch_crc_chk;
    logic ev_complete = 1'b0, ev_timeout = 1'b0, ev_index_err = 1'b0;
    logic ev_endbit_err = 1'b0, ev_crc_err = 1'b0, ev_removal = 1'b0;
    logic [127:0] rsp_in = '0;
    logic done;
    logic [2:0] result;
    logic [127:0] rsp_out;

    int total = 0;
    int bad = 0;
    logic [127:0] rsp_model = '0;

    always #10 clk = ~clk;

    sd_cmd_issue #(.POLL_LIMIT(LIMIT), .NUM_RSP_WORDS(4)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_arg(req_arg), .req_rsp_kind(req_rsp_kind), .req_cmd_kind(req_cmd_kind),
        .req_idx_chk(req_idx_chk), .req_crc_chk(req_crc_chk),
        .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit),
        .launch(launch), .launch_index(launch_index), .launch_arg(launch_arg),
        .launch_rsp_kind(launch_rsp_kind), .launch_kind(launch_kind),
        .launch_idx_chk(launch_idx_chk), .launch_crc_chk(launch_crc_chk),
        .ev_complete(ev_complete), .ev_timeout(ev_timeout), .ev_index_err(ev_index_err),
        .ev_endbit_err(ev_endbit_err), .ev_crc_err(ev_crc_err), .ev_removal(ev_removal),
        .rsp_in(rsp_in), .done(done), .result(result), .rsp_out(rsp_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected result from the priority order in R4/R5/R7/R8.
    function automatic logic [2:0] exp_result(input bit err, input bit rm, input bit to);
        if (err)     return 3'd1;
        else if (rm) return 3'd3;
        else if (to) return 3'd5;
        return 3'd0;
    endfunction

    task automatic do_cmd(input logic [5:0] ix, input logic [31:0] arg,
                          input logic [1:0] rk, input logic [1:0] kd,
                          input bit ie, input bit ce, input int inh, input bit pre_rm,
                          input int gap, input bit mid_rm,
                          input bit f_c, input bit f_t, input bit f_i, input bit f_e,
                          input bit f_r, input bit extra);
        bit err;
        logic [2:0] exp;
        logic [1:0] exp_rk;
        logic [127:0] new_rsp;
        err = (f_i && ie) || f_e || (f_r && ce);
        if (!err) f_c = 1'b1;
        if (extra && gap < 1) gap = 1;
        exp = exp_result(err, mid_rm, f_t);
        exp_rk = (kd == 2'd3) ? 2'd3 : rk;
        new_rsp = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        if (inh > 0) begin
            cmd_inhibit = $urandom_range(0, 1);
            dat_inhibit = !cmd_inhibit | $urandom_range(0, 1);
        end
        req_valid = 1'b1; req_index = ix; req_arg = arg; req_rsp_kind = rk;
        req_cmd_kind = kd; req_idx_chk = ie; req_crc_chk = ce;
        @(negedge clk);
        req_valid = 1'b0;
        ev_removal = pre_rm;
        for (int k = 0; k < inh; k++) begin
            @(negedge clk);
            ev_removal = 1'b0;
            chk(launch == 1'b0, "R2", "launch while inhibited", launch, 0);
        end
        cmd_inhibit = 1'b0; dat_inhibit = 1'b0;
        @(negedge clk);
        ev_removal = 1'b0;
        chk(launch == 1'b1, "R2", "launch pulse", launch, 1);
        chk({launch_index, launch_arg, launch_kind, launch_idx_chk, launch_crc_chk} ==
            {ix, arg, kd, ie, ce}, "R2", "launch fields",
            {launch_index, launch_arg, launch_kind, launch_idx_chk, launch_crc_chk},
            {ix, arg, kd, ie, ce});
        chk(launch_rsp_kind == exp_rk, "R3", "launch response kind", launch_rsp_kind, exp_rk);
        if (mid_rm && gap > 0) ev_removal = 1'b1;
        if (extra) begin
            req_valid = 1'b1; req_index = ~ix; req_arg = ~arg;
        end
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            ev_removal = 1'b0;
            req_valid = 1'b0;
        end
        chk(done == 1'b0, "R4", "done before flags", done, 0);
        ev_complete = f_c; ev_timeout = f_t; ev_index_err = f_i;
        ev_endbit_err = f_e; ev_crc_err = f_r; rsp_in = new_rsp;
        if (mid_rm && gap == 0) ev_removal = 1'b1;
        @(negedge clk);
        ev_complete = 0; ev_timeout = 0; ev_index_err = 0;
        ev_endbit_err = 0; ev_crc_err = 0; ev_removal = 0;
        chk(done == 1'b1, "R4", "done pulse", done, 1);
        chk(result == exp, exp == 3'd1 ? "R5" : exp == 3'd3 ? "R7" : exp == 3'd5 ? "R8" : "R6",
            "result code", result, exp);
        if (exp == 3'd0) rsp_model = new_rsp;
        chk(rsp_out == rsp_model, "R11", "response words", rsp_out, rsp_model);
        rsp_in = ~new_rsp;
        @(negedge clk);
        chk(done == 1'b0, "R4", "done single cycle", done, 0);
        if (extra) begin
            for (int k = 0; k < 3; k++) begin
                chk(launch == 1'b0, "R12", "no launch from ignored request", launch, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 0 && launch == 0, "R1", "reset pulses", {done, launch}, 0);
        chk(rsp_out == '0, "R1", "reset response", rsp_out, 0);

        // R6 clean success with fresh response capture
        do_cmd(6'd17, 32'h0000_0200, 2'd2, 2'd0, 1, 1, 2, 0, 1, 0, 1, 0, 0, 0, 0, 0);
        // R5 index error enabled beats removal and timeout
        do_cmd(6'd3, 32'h1, 2'd2, 2'd0, 1, 1, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0);
        // R6 index and CRC errors masked
        do_cmd(6'd41, 32'h0030_0000, 2'd2, 2'd0, 0, 0, 0, 0, 2, 0, 1, 0, 1, 0, 1, 0);
        // R7 removal with timeout and completion in the same cycle
        do_cmd(6'd7, 32'hABCD_0000, 2'd3, 2'd0, 1, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0);
        // R7 removal in an earlier cycle
        do_cmd(6'd9, 32'h5, 2'd1, 2'd0, 0, 1, 1, 0, 3, 1, 1, 0, 0, 0, 0, 0);
        // R8 timeout with completion
        do_cmd(6'd8, 32'h1AA, 2'd2, 2'd0, 1, 1, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0);
        // R9 removal while pending is not reported
        do_cmd(6'd16, 32'h200, 2'd2, 2'd0, 1, 1, 3, 1, 1, 0, 1, 0, 0, 0, 0, 0);
        // R3 abort with requested no-response forced to busy kind
        do_cmd(6'd12, 32'h0, 2'd0, 2'd3, 1, 1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
        // R12 request during the wait is ignored
        do_cmd(6'd55, 32'h1234_0000, 2'd2, 2'd0, 1, 1, 0, 0, 2, 0, 1, 0, 0, 0, 0, 1);

        // R10 no flags: poll window expiry
        @(negedge clk);
        req_valid = 1; req_index = 6'd2; req_arg = 0; req_rsp_kind = 2'd1; req_cmd_kind = 0;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(launch == 1'b1, "R10", "launch before expiry", launch, 1);
        cnt = 0;
        rsp_in = {4{32'hDEAD_BEEF}};
        while (!done && cnt < LIMIT + 5) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == LIMIT, "R10", "cycles launch to done", cnt, LIMIT);
        chk(result == 3'd1, "R10", "expiry result", result, 1);
        chk(rsp_out == rsp_model, "R11", "response kept on expiry", rsp_out, rsp_model);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            do_cmd(6'($urandom), $urandom, 2'($urandom), 2'($urandom),
                   1'($urandom), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
                   $urandom_range(0, 6), 1'($urandom_range(0, 3) == 0),
                   1'($urandom), 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0),
                   1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 3) == 0),
                   1'($urandom_range(0, 7) == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule